// File: doc/BRIEF.md
# Host Transport UART with Byte-Wise Flow Control

This block is a four-wire asynchronous serial transport that carries host/controller command and event bytes. It has a transmit queue and a receive queue of 32 bytes each, exchanged with the core over valid/ready byte streams. The host side has a transmit line, a receive line, a clear-to-send input that pauses the transmitter, and a request-to-send output that asks the host to stop sending once the receive queue fills past a programmable level.

After reset the link runs 8 data bits, no parity and one stop bit at 115.2 kbps. The 16x oversampling divisor comes from a fixed fast-clock frequency parameter. The core requests a new rate by presenting a divisor with a one-cycle strobe. The request is held pending and takes effect only once every queued byte has left the line at the old rate, so a confirming response written before the strobe always goes out at the rate the host still expects. Line and queue error conditions are collected in a sticky status word that is cleared by writing ones.

Top module: `uart_hci`

## Requirements
- R1: After reset txd_o is 1, rts_o is 0, status_o is 0, tx_ready_o is 1, rx_valid_o is 0 and baud_busy_o is 0. The active divisor is FCLK_HZ/(16*115200) fast clocks per oversampling tick, so one bit lasts 16 such ticks.
- R2: A transmitted frame is a start bit of 0, eight data bits LSB first, then a parity bit when par_en_i is 1 (the XOR of the data bits, inverted when par_odd_i is 1), then a stop bit of 1. Each bit lasts 16 ticks.
- R3: The receiver confirms the start bit at half a bit and samples each later bit at its middle. A low pulse shorter than half a bit yields no byte. Received bytes reach rx_data_o in arrival order.
- R4: rts_o is 1 exactly when receive queue occupancy exceeds rts_level_i (one cycle of latency).
- R5: While cts_i is high, no new frame starts. A frame already under way when cts_i rises is completed intact.
- R6: After a baud_set_i strobe, baud_busy_o is 1 and the divisor stays unchanged until the transmit queue is empty and the transmitter is idle. The stored baud_div_i then becomes active for both directions and baud_busy_o falls.
- R7: A stop bit sampled as 0 sets status bit 2 (framing). The byte is discarded, and the receiver waits for a high line before looking for a new start bit.
- R8: With par_en_i set, a received parity bit that disagrees with the rule of R2 sets status bit 3. The byte is still delivered.
- R9: A byte completed while the receive queue holds 32 bytes is dropped and sets status bit 4.
- R10: A line held low for one full frame time (16 ticks times 10 bits, or 11 with parity) sets status bit 0 (break). A line left high for one frame time after the last received frame sets status bit 1 (idle).
- R11: rx_ready_i high while the receive queue is empty sets status bit 5. A transmitted frame that ends with the transmit queue empty sets status bit 6.
- R12: Status bits are sticky and are cleared by the matching bits of status_clr_i. When a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line from host |
| txd_o | output | 1 | Serial transmit line to host |
| cts_i | input | 1 | High pauses new transmit frames |
| rts_o | output | 1 | High asks host to stop sending |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Transmit queue can accept a byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Core takes rx_data_o |
| par_en_i | input | 1 | Parity bit present in both directions |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| rts_level_i | input | 6 | Occupancy above which rts_o rises |
| baud_div_i | input | 16 | Requested fast clocks per oversampling tick |
| baud_set_i | input | 1 | Strobe that requests baud_div_i |
| baud_busy_o | output | 1 | A rate change is pending |
| status_o | output | 7 | Sticky flags: 0 break, 1 idle, 2 framing, 3 parity, 4 rx overflow, 5 rx underflow, 6 tx underflow |
| status_clr_i | input | 7 | Write-one-to-clear mask for status_o |

## Verification
The status register can receive a set and a clear for the same flag in one cycle. The bench provokes this by driving rx_ready_i against an empty receive queue in the very cycle that status_clr_i carries a one for the underflow bit. The flag must then read 1 at the next sample, and it must fall only after a later clear that arrives alone. A rate change can also be requested while a frame is still on the line. The bench checks that the frame in flight and the one queued behind it both decode at the old bit time, that the pending indication stays up between them, and that the next byte decodes at the new bit time.

// File: rtl/uart_hci_pkg.sv
package uart_hci_pkg;
  localparam int OSR    = 16;
  localparam int DBITS  = 8;
  localparam int ST_W   = 7;
  localparam int ST_BRK  = 0;
  localparam int ST_IDLE = 1;
  localparam int ST_FRM  = 2;
  localparam int ST_PAR  = 3;
  localparam int ST_ROVF = 4;
  localparam int ST_RUDF = 5;
  localparam int ST_TUDF = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT
  } bit_st_e;
endpackage

// File: rtl/uart_hci_fifo.sv
module uart_hci_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // callers gate writes with full_o; an ungated write would lose a byte
  assert_fifo_no_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/uart_hci_tick.sv
module uart_hci_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_hci_tx.sv
module uart_hci_tx
  import uart_hci_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cts_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       txd_o,
  output logic       idle_o,
  output logic       done_o
);
  bit_st_e    st_q;
  logic [3:0] sub_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic       par_q, txd_q, done_q;
  logic       bit_end;

  assign pop_o   = (st_q == S_IDLE) && tick_i && avail_i && !cts_i;
  assign bit_end = tick_i && (sub_q == 4'(OSR - 1));
  assign txd_o   = txd_q;
  assign idle_o  = (st_q == S_IDLE);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (pop_o) begin
          sh_q  <= data_i;
          par_q <= (^data_i) ^ par_odd_i;
          txd_q <= 1'b0;
          sub_q <= '0;
          idx_q <= '0;
          st_q  <= S_START;
        end
      end else if (tick_i) begin
        sub_q <= sub_q + 1'b1;
        if (bit_end) begin
          sub_q <= '0;
          case (st_q)
            S_START: begin
              txd_q <= sh_q[0];
              st_q  <= S_DATA;
            end
            S_DATA: begin
              sh_q <= sh_q >> 1;
              if (idx_q == 3'(DBITS - 1)) begin
                txd_q <= par_en_i ? par_q : 1'b1;
                st_q  <= par_en_i ? S_PAR : S_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
                txd_q <= sh_q[1];
              end
            end
            S_PAR: begin
              txd_q <= 1'b1;
              st_q  <= S_STOP;
            end
            default: begin
              txd_q  <= 1'b1;
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

  assert_cts_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && cts_i) |=> (st_q == S_IDLE && txd_o));
endmodule

// File: rtl/uart_hci_rx.sv
module uart_hci_rx
  import uart_hci_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       frm_o,
  output logic       perr_o,
  output logic       brk_o,
  output logic       idle_o
);
  localparam int FRW = 10;

  bit_st_e        st_q;
  logic [3:0]     sub_q;
  logic [2:0]     idx_q;
  logic [7:0]     sh_q;
  logic           pbit_q, valid_q, frm_q, perr_q, brk_q, idle_q, armed_q;
  logic [FRW-1:0] lo_q, hi_q, frame_t;
  logic           mid, half, stop_end;

  assign frame_t  = FRW'(OSR * (DBITS + 2)) + (par_en_i ? FRW'(OSR) : '0);
  assign mid      = tick_i && (sub_q == 4'(OSR - 1));
  assign half     = tick_i && (sub_q == 4'(OSR / 2 - 1));
  assign stop_end = (st_q == S_STOP) && mid;
  assign data_o   = sh_q;
  assign valid_o  = valid_q;
  assign frm_o    = frm_q;
  assign perr_o   = perr_q;
  assign brk_o    = brk_q;
  assign idle_o   = idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      valid_q <= 1'b0;
      frm_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      frm_q   <= 1'b0;
      perr_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (tick_i && !rxd_i) begin
          sub_q <= '0;
          st_q  <= S_START;
        end
        S_START: if (tick_i) begin
          sub_q <= sub_q + 1'b1;
          if (half) begin
            sub_q <= '0;
            idx_q <= '0;
            st_q  <= rxd_i ? S_IDLE : S_DATA;
          end
        end
        S_WAIT: if (rxd_i) st_q <= S_IDLE;
        default: if (tick_i) begin
          sub_q <= sub_q + 1'b1;
          if (mid) begin
            sub_q <= '0;
            if (st_q == S_DATA) begin
              sh_q <= {rxd_i, sh_q[7:1]};
              if (idx_q == 3'(DBITS - 1)) st_q <= par_en_i ? S_PAR : S_STOP;
              else                        idx_q <= idx_q + 1'b1;
            end else if (st_q == S_PAR) begin
              pbit_q <= rxd_i;
              st_q   <= S_STOP;
            end else if (!rxd_i) begin
              frm_q <= 1'b1;
              st_q  <= S_WAIT;
            end else begin
              valid_q <= 1'b1;
              perr_q  <= par_en_i && (pbit_q != ((^sh_q) ^ par_odd_i));
              st_q    <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  // break and idle timers in oversampling ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      brk_q  <= 1'b0;
      idle_q <= 1'b0;
      if (!rxd_i) hi_q <= '0;
      if (tick_i) begin
        if (rxd_i) lo_q <= '0;
        else if (lo_q < frame_t) begin
          lo_q  <= lo_q + 1'b1;
          brk_q <= (lo_q == frame_t - 1'b1);
        end
        if (rxd_i && armed_q) begin
          if (hi_q == frame_t - 1'b1) begin
            idle_q  <= 1'b1;
            armed_q <= 1'b0;
            hi_q    <= '0;
          end else hi_q <= hi_q + 1'b1;
        end
      end
      if (stop_end) begin
        armed_q <= 1'b1;
        hi_q    <= '0;
      end
    end
  end

  assert_start_recheck_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_START && half && rxd_i) |=> (st_q == S_IDLE && !valid_o));
  assert_frame_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_end && !rxd_i) |=> (frm_o && !valid_o));
endmodule

// File: rtl/uart_hci.sv
module uart_hci
  import uart_hci_pkg::*;
#(
  parameter int FCLK_HZ  = 48_000_000,
  parameter int DEF_BAUD = 115_200,
  parameter int DEPTH    = 32,
  parameter int DIV_W    = 16,
  localparam int CW      = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  output logic             txd_o,
  input  logic             cts_i,
  output logic             rts_o,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic [CW-1:0]    rts_level_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             baud_set_i,
  output logic             baud_busy_o,
  output logic [ST_W-1:0]  status_o,
  input  logic [ST_W-1:0]  status_clr_i
);
  localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(FCLK_HZ / (OSR * DEF_BAUD));

  logic [1:0]       rxd_sq, cts_sq;
  logic             rxd_s, cts_s, tick;
  logic [DIV_W-1:0] div_q, pend_div_q;
  logic             pend_q, apply;
  logic             rts_q;
  logic [ST_W-1:0]  st_q, st_set;

  logic       tx_full, tx_empty, tx_pop, tx_idle, tx_done;
  logic [7:0] tx_head;
  logic [CW-1:0] tx_cnt;
  logic       rx_full, rx_empty, rx_byte, rx_frm, rx_perr, rx_brk, rx_idle;
  logic [7:0] rx_byte_data;
  logic [CW-1:0] rx_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_sq <= 2'b11;
      cts_sq <= 2'b11;
    end else begin
      rxd_sq <= {rxd_sq[0], rxd_i};
      cts_sq <= {cts_sq[0], cts_i};
    end
  end
  assign rxd_s = rxd_sq[1];
  assign cts_s = cts_sq[1];

  // rate change waits until every queued byte has left at the old rate
  assign apply = pend_q && tx_empty && tx_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= DEF_DIV;
      pend_div_q <= DEF_DIV;
      pend_q     <= 1'b0;
    end else if (baud_set_i) begin
      pend_q     <= 1'b1;
      pend_div_q <= baud_div_i;
    end else if (apply) begin
      pend_q <= 1'b0;
      div_q  <= pend_div_q;
    end
  end
  assign baud_busy_o = pend_q;

  uart_hci_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q), .tick_o(tick)
  );

  assign tx_ready_o = !tx_full;

  uart_hci_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(tx_valid_i && !tx_full), .wdata_i(tx_data_i),
    .pop_i(tx_pop), .rdata_o(tx_head),
    .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_cnt)
  );

  uart_hci_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cts_i(cts_s),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .avail_i(!tx_empty), .data_i(tx_head), .pop_o(tx_pop),
    .txd_o(txd_o), .idle_o(tx_idle), .done_o(tx_done)
  );

  uart_hci_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_s),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .data_o(rx_byte_data), .valid_o(rx_byte), .frm_o(rx_frm),
    .perr_o(rx_perr), .brk_o(rx_brk), .idle_o(rx_idle)
  );

  uart_hci_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(rx_byte && !rx_full), .wdata_i(rx_byte_data),
    .pop_i(rx_ready_i), .rdata_o(rx_data_o),
    .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_cnt)
  );
  assign rx_valid_o = !rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_q <= 1'b0;
    else         rts_q <= (rx_cnt > rts_level_i);
  end
  assign rts_o = rts_q;

  always_comb begin
    st_set          = '0;
    st_set[ST_BRK]  = rx_brk;
    st_set[ST_IDLE] = rx_idle;
    st_set[ST_FRM]  = rx_frm;
    st_set[ST_PAR]  = rx_perr;
    st_set[ST_ROVF] = rx_byte && rx_full;
    st_set[ST_RUDF] = rx_ready_i && rx_empty;
    st_set[ST_TUDF] = tx_done && tx_empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~status_clr_i) | st_set;
  end
  assign status_o = st_q;

  assert_baud_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tx_empty) |=> $stable(div_q));
  assert_rx_overflow_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte && rx_full) |=> (status_o[ST_ROVF] && $stable(rx_cnt)));
  assert_set_beats_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_i && rx_empty) |=> status_o[ST_RUDF]);
  assert_rts_follows_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt <= rts_level_i && $stable(rts_level_i) && !rx_byte) |=> !rts_o);
endmodule

// File: tb/uart_hci_tb.sv
module uart_hci_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FCLK       = 3_686_400;  // divisor 2 at 115.2k
  localparam int BITC       = 32;         // 16 ticks * 2 clocks
  localparam int FASTC      = 16;         // after change to divisor 1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, cts = 1'b0;
  logic txd, rts;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic [5:0] rts_level = 6'd16;
  logic [15:0] baud_div = 16'd2;
  logic baud_set = 1'b0, baud_busy;
  logic [6:0] status, status_clr = '0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_hci #(.FCLK_HZ(FCLK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .txd_o(txd), .cts_i(cts), .rts_o(rts),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .par_en_i(par_en), .par_odd_i(par_odd), .rts_level_i(rts_level),
    .baud_div_i(baud_div), .baud_set_i(baud_set), .baud_busy_o(baud_busy),
    .status_o(status), .status_clr_i(status_clr)
  );

  function automatic logic exp_par(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk); b = rx_data; rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clr(input logic [6:0] m);
    @(negedge clk); status_clr = m;
    @(negedge clk); status_clr = '0;
  endtask

  task automatic line_send(input logic [7:0] b, input int bc, input logic stop_v,
                           input logic pe, input logic pv);
    @(negedge clk); rxd = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bc) @(negedge clk); end
    if (pe) begin rxd = pv; repeat (bc) @(negedge clk); end
    rxd = stop_v; repeat (bc) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic line_recv(input int bc, input logic pe, output logic [7:0] b,
                           output logic pb, output logic stp);
    while (txd !== 1'b0) @(negedge clk);
    repeat (bc/2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (bc) @(negedge clk); b[i] = txd; end
    pb = 1'b0;
    if (pe) begin repeat (bc) @(negedge clk); pb = txd; end
    repeat (bc) @(negedge clk); stp = txd;
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b, b2, got;
    logic pb, stp;
    logic [7:0] sent [40];
    int lows;
    void'($urandom(32'd7331));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 rts", rts, 0); chk("R1 status", status, 0);
    chk("R1 tx_ready", tx_ready, 1); chk("R1 rx_valid", rx_valid, 0);
    chk("R1 busy", baud_busy, 0);

    // R1/R2: default rate, 8N1
    push_tx(8'hA5);
    line_recv(BITC, 1'b0, got, pb, stp);
    chk("R1 default-rate byte", got, 8'hA5); chk("R2 stop", stp, 1);
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      par_en = (k >= 2); par_odd = (k == 3);
      push_tx(b);
      line_recv(BITC, par_en, got, pb, stp);
      chk("R2 data", got, b);
      if (par_en) chk("R2 parity", pb, exp_par(b, par_odd));
      chk("R2 stop", stp, 1);
    end
    par_en = 1'b0; par_odd = 1'b0;
    repeat (40) @(negedge clk);

    // R3 receive in order
    for (int k = 0; k < 3; k++) begin
      sent[k] = 8'($urandom);
      line_send(sent[k], BITC, 1'b1, 1'b0, 1'b0);
    end
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      pop_rx(got); chk("R3 order", got, sent[k]);
    end
    chk("R3 drained", rx_valid, 0);
    // R3 glitch shorter than half a bit
    @(negedge clk); rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (3*BITC*10) @(negedge clk);
    chk("R3 glitch ignored", rx_valid, 0);

    // R4 and R9
    clr(7'h7F);
    for (int k = 0; k < 33; k++) begin
      sent[k] = 8'($urandom);
      line_send(sent[k], BITC, 1'b1, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      if (k == 15) chk("R4 rts at 16", rts, 0);
      if (k == 16) chk("R4 rts at 17", rts, 1);
    end
    chk("R9 overflow flag", status[4], 1);
    for (int k = 0; k < 32; k++) begin
      pop_rx(got); chk("R9 kept bytes", got, sent[k]);
    end
    @(negedge clk);
    chk("R9 dropped byte", rx_valid, 0); chk("R4 rts low", rts, 0);

    // R10 idle
    clr(7'h7F);
    line_send(8'h3C, BITC, 1'b1, 1'b0, 1'b0);
    repeat (BITC) @(negedge clk);
    chk("R10 idle not early", status[1], 0);
    repeat (11*BITC) @(negedge clk);
    chk("R10 idle", status[1], 1);
    pop_rx(got); chk("R3 byte", got, 8'h3C);

    // R7 framing
    clr(7'h7F);
    line_send(8'hFF, BITC, 1'b0, 1'b0, 1'b0);
    repeat (3*BITC) @(negedge clk);
    chk("R7 framing", status[2], 1); chk("R7 no break", status[0], 0);
    chk("R7 byte discarded", rx_valid, 0);

    // R10 break
    clr(7'h7F);
    @(negedge clk); rxd = 1'b0; repeat (12*BITC) @(negedge clk); rxd = 1'b1;
    repeat (2*BITC) @(negedge clk);
    chk("R10 break", status[0], 1); chk("R7 break frame", status[2], 1);
    chk("R7 break no byte", rx_valid, 0);

    // R8 parity
    clr(7'h7F);
    par_en = 1'b1;
    line_send(8'h3C, BITC, 1'b1, 1'b1, ~exp_par(8'h3C, 1'b0));
    repeat (4) @(negedge clk);
    chk("R8 parity error", status[3], 1);
    pop_rx(got); chk("R8 byte delivered", got, 8'h3C);
    clr(7'h7F);
    b = 8'($urandom);
    line_send(b, BITC, 1'b1, 1'b1, exp_par(b, 1'b0));
    repeat (4) @(negedge clk);
    chk("R8 parity ok", status[3], 0);
    pop_rx(got); chk("R8 good byte", got, b);
    par_en = 1'b0;

    // R5 CTS held before start
    @(negedge clk); cts = 1'b1; repeat (4) @(negedge clk);
    push_tx(8'h6E);
    count_lows(4*BITC, lows);
    chk("R5 held by cts", lows, 0);
    cts = 1'b0;
    line_recv(BITC, 1'b0, got, pb, stp);
    chk("R5 released byte", got, 8'h6E);
    // R5 CTS rising mid-byte
    push_tx(8'h96); push_tx(8'h5A);
    fork
      line_recv(BITC, 1'b0, got, pb, stp);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (2*BITC) @(negedge clk);
        cts = 1'b1;
      end
    join
    chk("R5 byte completed", got, 8'h96); chk("R5 stop intact", stp, 1);
    count_lows(5*BITC, lows);
    chk("R5 next held", lows, 0);
    cts = 1'b0;
    line_recv(BITC, 1'b0, got, pb, stp);
    chk("R5 next byte", got, 8'h5A);
    repeat (BITC) @(negedge clk);

    // R6 deferred rate change
    push_tx(8'h11); push_tx(8'h22);
    @(negedge clk); baud_div = 16'd1; baud_set = 1'b1;
    @(negedge clk); baud_set = 1'b0;
    chk("R6 busy", baud_busy, 1);
    line_recv(BITC, 1'b0, got, pb, stp);
    chk("R6 old rate 1", got, 8'h11);
    chk("R6 still busy", baud_busy, 1);
    line_recv(BITC, 1'b0, b2, pb, stp);
    chk("R6 old rate 2", b2, 8'h22);
    repeat (BITC) @(negedge clk);
    chk("R6 applied", baud_busy, 0);
    push_tx(8'h33);
    line_recv(FASTC, 1'b0, got, pb, stp);
    chk("R6 new rate tx", got, 8'h33); chk("R6 new rate stop", stp, 1);
    b = 8'($urandom);
    line_send(b, FASTC, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    pop_rx(got); chk("R6 new rate rx", got, b);

    // R11 tx underflow
    clr(7'h7F);
    push_tx(8'hC3);
    line_recv(FASTC, 1'b0, got, pb, stp);
    repeat (FASTC) @(negedge clk);
    chk("R11 tx underflow", status[6], 1);

    // R11/R12 set and clear in the same cycle
    clr(7'h7F);
    @(negedge clk); rx_ready = 1'b1; status_clr = 7'h20;
    @(negedge clk); rx_ready = 1'b0; status_clr = '0;
    chk("R12 set wins", status[5], 1);
    chk("R11 rx underflow only", status, 7'h20);
    clr(7'h20);
    chk("R12 w1c", status[5], 0);

    summary();
    $finish;
  end
endmodule